// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block is a synchronous controller for an asynchronous fast page mode DRAM holding 2M words of 8 bits. The memory's 21-bit word address is split into an 11-bit row and a 10-bit column, and both go out over one shared address bus. On the host side the controller takes one request at a time. A request carries a word address, a write flag and write data. The controller answers with a one-cycle done pulse, and after a read that pulse comes with the read data.

After an access the controller leaves the row open. A later request to the same row then needs only a column strobe. A request to a different row first closes the open row, waits out the precharge time and the minimum row cycle, and then opens the new row. A free-running interval timer raises a refresh request. That request closes any open row and runs a refresh cycle in which the column strobe goes low before the row strobe, and it is served ahead of the next host request.

Every analog limit is held as a whole number of clock cycles set by parameters. The defaults assume a 100 MHz clock and the fastest speed grade.

Top module: `fpm_ctrl`

## Requirements
- R1: While reset is held, and afterwards until the first request, `mem_ras_n`, `mem_cas_n`, `mem_we_n` and `mem_oe_n` are all high, `mem_dq_oe` is low and `host_done` is low.
- R2: The row is `host_addr[20:10]` and the column is `host_addr[9:0]`. The row is driven on `mem_addr` when `mem_ras_n` falls, and the column (zero-extended to 11 bits) is driven when `mem_cas_n` falls. A word that is written reads back unchanged at the same address.
- R3: A request to the row that is already open causes no `mem_ras_n` fall. Its `host_done` rises at the (T_CAC+1)th rising clock edge after the edge that accepted the request.
- R4: A request to a closed or different row first holds `mem_ras_n` high for at least T_RP cycles. Two successive falls of `mem_ras_n` are always at least T_RC cycles apart. Such a request takes longer than a request to the open row.
- R5: Read data is captured no earlier than T_RAC cycles after `mem_ras_n` fell and no earlier than T_CAC cycles after `mem_cas_n` fell.
- R6: Two successive falls of `mem_cas_n` are at least T_PC cycles apart.
- R7: A write drives `mem_we_n` low at least one cycle before `mem_cas_n` falls. `mem_oe_n` is never low while `mem_we_n` is low.
- R8: A refresh is requested every REF_INT cycles. In a refresh cycle `mem_cas_n` is low for at least one cycle before `mem_ras_n` falls. Over an idle window of W cycles the number of refreshes is W/REF_INT ± 1.
- R9: `host_done` is high for exactly one cycle per request. After a read, `host_rdata` holds the captured word in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Request present; held with its fields until done |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 21 | Word address, row in the upper 11 bits |
| host_wdata | input | 8 | Write data |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Read data, valid with done |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | 11 | Multiplexed row/column address |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enables the data driver during writes |
| mem_dq_in | input | 8 | Data returned by the memory |

## Verification
Under default parameters, a request to the open row finishes at the fourth edge counted from the accepting edge (T_CAC+2). A request to a closed row opens it at the accepting edge and can capture no earlier than six edges later, when the T_RAC limit allows. The bench's memory model counts whole cycles from each strobe fall and returns the filler value 0xEE until both access limits have passed. A capture made too early therefore shows up as a data mismatch. Hit latency is checked by exact edge count only when no refresh fell inside the request. The pulse width and the idle state are sampled at the falling edge after each change.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_COLSET,
        ST_STROBE,
        ST_PRECH,
        ST_RFC,
        ST_RFR
    } fpm_state_e;

    localparam int N_TIMERS = 3;
    localparam int TMR_RAS  = 0;
    localparam int TMR_CAS  = 1;
    localparam int TMR_PRE  = 2;

endpackage

// File: rtl/fpm_elapsed.sv
module fpm_elapsed #(
    parameter int W   = 4,
    parameter int MAX = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)
            cnt_d = W'(1);
        else if (cnt_q < W'(MAX))
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= W'(MAX);
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/fpm_ref_timer.sv
module fpm_ref_timer #(
    parameter int INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    output logic pending
);
    localparam int CW = $clog2(INTERVAL);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pend;
    } tmr_t;

    tmr_t t_d, t_q;
    logic tick;

    always_comb begin
        t_d  = t_q;
        tick = (t_q.cnt == CW'(INTERVAL - 1));
        t_d.cnt  = tick ? '0 : t_q.cnt + CW'(1);
        t_d.pend = tick | (t_q.pend & ~ack);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign pending = t_q.pend;

    p_one_per_interval_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.pend && !ack) |=> t_q.pend);
endmodule

// File: rtl/fpm_ctrl.sv
module fpm_ctrl #(
    parameter int ROW_W   = 11,
    parameter int COL_W   = 10,
    parameter int DW      = 8,
    parameter int T_RC    = 11,
    parameter int T_PC    = 4,
    parameter int T_RAC   = 6,
    parameter int T_CAC   = 2,
    parameter int T_RP    = 4,
    parameter int T_RASMN = 6,
    parameter int REF_INT = 1560
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_valid,
    input  logic                   host_write,
    input  logic [ROW_W+COL_W-1:0] host_addr,
    input  logic [DW-1:0]          host_wdata,
    output logic                   host_done,
    output logic [DW-1:0]          host_rdata,
    output logic                   mem_ras_n,
    output logic                   mem_cas_n,
    output logic                   mem_we_n,
    output logic                   mem_oe_n,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] mem_addr,
    output logic [DW-1:0]          mem_dq_out,
    output logic                   mem_dq_oe,
    input  logic [DW-1:0]          mem_dq_in
);
    import fpm_pkg::*;

    localparam int MA_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int MX1   = (T_RC > T_RASMN) ? T_RC : T_RASMN;
    localparam int MX2   = (T_PC > T_RP) ? T_PC : T_RP;
    localparam int MX3   = (T_RAC > T_CAC) ? T_RAC : T_CAC;
    localparam int MX12  = (MX1 > MX2) ? MX1 : MX2;
    localparam int CNT_MAX = (MX12 > MX3) ? MX12 : MX3;
    localparam int CW    = $clog2(CNT_MAX + 1) + 1;

    typedef struct packed {
        fpm_state_e       st;
        logic             ras_n;
        logic             cas_n;
        logic             we_n;
        logic             oe_n;
        logic [MA_W-1:0]  ma;
        logic             dq_oe;
        logic [DW-1:0]    wdata;
        logic [DW-1:0]    rdata;
        logic             done;
        logic             open;
        logic [ROW_W-1:0] open_row;
        logic             wr;
    } regs_t;

    regs_t r_d, r_q;

    logic [N_TIMERS-1:0] restart;
    logic [CW-1:0]       since [N_TIMERS];
    logic                ref_pend, ref_ack;

    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    assign req_row = host_addr[ROW_W+COL_W-1:COL_W];
    assign req_col = host_addr[COL_W-1:0];

    for (genvar g = 0; g < N_TIMERS; g++) begin : g_tmr
        fpm_elapsed #(.W(CW), .MAX(CNT_MAX)) u_el (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (restart[g]),
            .count   (since[g])
        );
    end

    fpm_ref_timer #(.INTERVAL(REF_INT)) u_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack     (ref_ack),
        .pending (ref_pend)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        ref_ack  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (ref_pend) begin
                    if (r_q.open) begin
                        r_d.st    = ST_PRECH;
                        r_d.ras_n = 1'b1;
                        r_d.open  = 1'b0;
                    end else begin
                        r_d.st    = ST_RFC;
                        r_d.cas_n = 1'b0;
                        ref_ack   = 1'b1;
                    end
                end else if (host_valid) begin
                    if (r_q.open && (r_q.open_row == req_row)) begin
                        r_d.st    = ST_COLSET;
                        r_d.ma    = MA_W'(req_col);
                        r_d.we_n  = ~host_write;
                        r_d.dq_oe = host_write;
                        r_d.wr    = host_write;
                        r_d.wdata = host_wdata;
                    end else if (r_q.open) begin
                        r_d.st    = ST_PRECH;
                        r_d.ras_n = 1'b1;
                        r_d.open  = 1'b0;
                    end else begin
                        r_d.st       = ST_OPEN;
                        r_d.ras_n    = 1'b0;
                        r_d.ma       = MA_W'(req_row);
                        r_d.open     = 1'b1;
                        r_d.open_row = req_row;
                        r_d.wr       = host_write;
                        r_d.wdata    = host_wdata;
                    end
                end
            end
            ST_OPEN: begin
                r_d.st    = ST_COLSET;
                r_d.ma    = MA_W'(req_col);
                r_d.we_n  = ~r_q.wr;
                r_d.dq_oe = r_q.wr;
            end
            ST_COLSET: begin
                if (since[TMR_CAS] >= CW'(T_PC)) begin
                    r_d.st    = ST_STROBE;
                    r_d.cas_n = 1'b0;
                    r_d.oe_n  = r_q.wr;
                end
            end
            ST_STROBE: begin
                if ((since[TMR_CAS] >= CW'(T_CAC)) &&
                    (r_q.wr || (since[TMR_RAS] >= CW'(T_RAC)))) begin
                    r_d.st    = ST_IDLE;
                    r_d.cas_n = 1'b1;
                    r_d.oe_n  = 1'b1;
                    r_d.we_n  = 1'b1;
                    r_d.dq_oe = 1'b0;
                    r_d.done  = 1'b1;
                    if (!r_q.wr) r_d.rdata = mem_dq_in;
                end
            end
            ST_PRECH: begin
                if ((since[TMR_PRE] >= CW'(T_RP)) && (since[TMR_RAS] >= CW'(T_RC)))
                    r_d.st = ST_IDLE;
            end
            ST_RFC: begin
                r_d.st    = ST_RFR;
                r_d.ras_n = 1'b0;
            end
            ST_RFR: begin
                if (since[TMR_RAS] >= CW'(T_RASMN)) begin
                    r_d.st    = ST_PRECH;
                    r_d.ras_n = 1'b1;
                    r_d.cas_n = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        restart[TMR_RAS] = r_q.ras_n & ~r_d.ras_n;
        restart[TMR_CAS] = r_q.cas_n & ~r_d.cas_n;
        restart[TMR_PRE] = ~r_q.ras_n & r_d.ras_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.ras_n <= 1'b1;
            r_q.cas_n <= 1'b1;
            r_q.we_n  <= 1'b1;
            r_q.oe_n  <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign host_done  = r_q.done;
    assign host_rdata = r_q.rdata;
    assign mem_ras_n  = r_q.ras_n;
    assign mem_cas_n  = r_q.cas_n;
    assign mem_we_n   = r_q.we_n;
    assign mem_oe_n   = r_q.oe_n;
    assign mem_addr   = r_q.ma;
    assign mem_dq_out = r_q.wdata;
    assign mem_dq_oe  = r_q.dq_oe;

    // Independent pin-level gap counters used only by the properties below
    logic [CW-1:0] a_ras_gap, a_cas_gap;
    logic          a_ras_prev, a_cas_prev;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_ras_gap  <= CW'(CNT_MAX);
            a_cas_gap  <= CW'(CNT_MAX);
            a_ras_prev <= 1'b1;
            a_cas_prev <= 1'b1;
        end else begin
            a_ras_prev <= mem_ras_n;
            a_cas_prev <= mem_cas_n;
            if (a_ras_prev && !mem_ras_n)        a_ras_gap <= CW'(1);
            else if (a_ras_gap < CW'(CNT_MAX))   a_ras_gap <= a_ras_gap + CW'(1);
            if (a_cas_prev && !mem_cas_n)        a_cas_gap <= CW'(1);
            else if (a_cas_gap < CW'(CNT_MAX))   a_cas_gap <= a_cas_gap + CW'(1);
        end
    end

    p_row_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ras_n) |-> (a_ras_gap >= CW'(T_RC)));

    p_page_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cas_n) |-> (a_cas_gap >= CW'(T_PC)));

    p_early_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_cas_n) && !mem_we_n) |-> !$past(mem_we_n));

    p_oe_we_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> mem_we_n);

    p_cbr_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_ras_n) && !mem_cas_n) |-> !$past(mem_cas_n));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);
endmodule

// File: tb/sim_fpm_ctrl.sv
module sim_fpm_ctrl;
    localparam int T_RC = 11, T_PC = 4, T_RAC = 6, T_CAC = 2, T_RP = 4;
    localparam int REF_INT = 1560;
    localparam int WIN = 16000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0, host_write = 1'b0;
    logic [20:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_done;
    logic [7:0]  host_rdata;
    logic        mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [10:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;

    int total = 0, bad = 0;

    always #10 clk = ~clk;

    fpm_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .host_valid(host_valid), .host_write(host_write),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_done(host_done), .host_rdata(host_rdata),
        .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- memory model, evaluated at falling edges ----------------
    logic [7:0] mem [int];
    logic [10:0] row_l = '0;
    logic [9:0]  col_l = '0;
    int ras_gap = 1000, cas_gap = 1000, ras_age = 1000, cas_age = 1000, hi_len = 1000;
    int ref_cnt = 0, ras_falls = 0;
    logic pr_ras = 1'b1, pr_cas = 1'b1, pr_we = 1'b1;

    function automatic logic [7:0] mem_rd(input int k);
        return mem.exists(k) ? mem[k] : 8'h00;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (pr_ras && !mem_ras_n) begin
                if (ras_falls + ref_cnt > 0) begin
                    check(ras_gap >= T_RC, "R4 ras fall gap", ras_gap, T_RC);
                    check(hi_len >= T_RP, "R4 precharge", hi_len, T_RP);
                end
                ras_gap = 1; ras_age = 1;
                if (!mem_cas_n) ref_cnt++;
                else begin row_l = mem_addr; ras_falls++; end
            end else begin
                ras_gap++; ras_age++;
            end
            hi_len = mem_ras_n ? hi_len + 1 : 0;
            if (pr_cas && !mem_cas_n) begin
                if (!mem_ras_n) begin
                    check(cas_gap >= T_PC, "R6 cas fall gap", cas_gap, T_PC);
                    col_l = mem_addr[9:0];
                    if (!mem_we_n) begin
                        check(!pr_we, "R7 we before cas", pr_we, 0);
                        check(mem_oe_n, "R7 oe high in write", mem_oe_n, 1);
                        mem[{row_l, col_l}] = mem_dq_out;
                    end
                end
                cas_gap = 1; cas_age = 1;
            end else begin
                cas_gap++; cas_age++;
            end
            pr_ras = mem_ras_n; pr_cas = mem_cas_n; pr_we = mem_we_n;
            if (!mem_ras_n && !mem_cas_n && !mem_oe_n && cas_age >= T_CAC && ras_age >= T_RAC)
                mem_dq_in = mem_rd({row_l, col_l});
            else
                mem_dq_in = 8'hEE;
        end
    end

    // ---------------- host driver and reference ----------------
    logic [7:0] gold [int];
    logic [10:0] b_row = '0;
    bit b_open = 1'b0;
    int last_ref = 0;

    task automatic txn(input bit wr, input logic [20:0] a, input logic [7:0] d);
        int lat = 0, rf0, rs0;
        bit hit, to = 1'b0;
        @(negedge clk);
        if (ref_cnt != last_ref) b_open = 1'b0;
        hit = b_open && (b_row == a[20:10]);
        rf0 = ref_cnt; rs0 = ras_falls;
        host_valid = 1'b1; host_write = wr; host_addr = a; host_wdata = d;
        forever begin
            @(negedge clk);
            lat++;
            if (host_done) break;
            if (lat > 300) begin to = 1'b1; break; end
        end
        host_valid = 1'b0;
        check(!to, "R9 done timeout", lat, 300);
        if (wr) gold[a] = d;
        else check(host_rdata == (gold.exists(a) ? gold[a] : 8'h00), "R2 R5 read data",
                   host_rdata, gold.exists(a) ? gold[a] : 8'h00);
        if (ref_cnt == rf0) begin
            if (hit) begin
                check(lat == T_CAC + 2, "R3 hit latency", lat, T_CAC + 2);
                check(ras_falls == rs0, "R3 no ras on hit", ras_falls - rs0, 0);
            end else begin
                check(lat > T_CAC + 2, "R4 miss slower", lat, T_CAC + 3);
            end
        end
        b_open = 1'b1; b_row = a[20:10]; last_ref = ref_cnt;
        @(negedge clk);
        check(!host_done, "R9 done pulse width", host_done, 0);
    endtask

    initial begin
        logic [10:0] pool [4];
        pool[0] = 11'd0; pool[1] = 11'd5; pool[2] = 11'd1024; pool[3] = 11'd2047;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(mem_ras_n && mem_cas_n && mem_we_n && mem_oe_n, "R1 strobes in reset",
              {mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n}, 15);
        check(!host_done && !mem_dq_oe, "R1 done/oe in reset", {host_done, mem_dq_oe}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(mem_ras_n && mem_cas_n && mem_we_n && mem_oe_n, "R1 strobes idle",
              {mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n}, 15);

        // Directed corners
        txn(1'b0, 21'h000123, 8'h00);
        txn(1'b1, 21'h1FFFFF, 8'hA5);
        check(row_l == 11'd2047, "R2 max row", row_l, 2047);
        check(col_l == 10'd1023, "R2 max col", col_l, 1023);
        txn(1'b0, 21'h1FFFFF, 8'h00);
        txn(1'b1, 21'h000000, 8'h3C);
        check(row_l == 11'd0 && col_l == 10'd0, "R2 zero address", {row_l, col_l}, 0);
        txn(1'b0, 21'h000000, 8'h00);
        txn(1'b0, 21'h1FFFFF, 8'h00);

        // Constrained random traffic over a few rows
        for (int i = 0; i < 400; i++) begin
            logic [20:0] a;
            a = {pool[$urandom_range(0, 3)], 10'($urandom_range(0, 15))};
            txn(1'($urandom_range(0, 1)), a, 8'($urandom));
        end

        // Idle window: refresh rate
        begin
            int r0;
            r0 = ref_cnt;
            repeat (WIN) @(negedge clk);
            check((ref_cnt - r0) >= WIN / REF_INT - 1 && (ref_cnt - r0) <= WIN / REF_INT + 1,
                  "R8 refresh count", ref_cnt - r0, WIN / REF_INT);
        end
        check(mem_ras_n && mem_cas_n, "R8 strobes released after refresh",
              {mem_ras_n, mem_cas_n}, 3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule